// File: doc/BRIEF.md
# Transfer Completion Timeout Timer

This block guards a queue of host transfers that are being retried because the far end keeps answering with NAK. Software programs an 8-bit limit in milliseconds. A millisecond counter advances on a 1 ms tick while transfers are present in the queue. If the limit is reached before any transfer has completed, a sticky interrupt status bit is raised. Software then drops transfers that have stalled, or lowers their priority.

Transfer completion is reported through a 32-bit done map with one bit per queue slot. Any nonzero done map restarts the count, and a write to the limit register also restarts it. A limit of zero turns the timer off. Software writes zero when it wants no timeout indication, or when the queue holds nothing. After the interrupt fires, the timer stays quiet until the count has been restarted.

Top module: `xfer_timeout_timer`

## Requirements
- R1: After reset, `cfg_rd_data` reads 0x0001 and `irq_status` is 0.
- R2: `cfg_rd_data[7:0]` returns the last value written to `cfg_wr_data[7:0]`. `cfg_rd_data[15:8]` always reads 0, and writes to bits 15:8 have no effect.
- R3: A tick is counted when `ms_tick` and `active_present` are both high, the limit is nonzero, and no restart happens in that cycle. When the counted tick is the limit-th one since the last restart, `irq_status` becomes 1 in the following cycle.
- R4: A write to the limit register restarts the count. A tick in the same cycle as the write is not counted, and later ticks are compared against the new limit.
- R5: In any cycle where `done_map` is nonzero, the count restarts and no timeout can fire.
- R6: Ticks that arrive while `active_present` is 0 are not counted.
- R7: Once set, `irq_status` stays 1 until a cycle with `irq_clr` high. It reads 0 in the following cycle.
- R8: While the limit is 0, `irq_status` never becomes 1.
- R9: After a timeout fires, further ticks raise no new timeout until the count is restarted by R4 or R5.
- R10: If a timeout fires in the same cycle as `irq_clr`, `irq_status` reads 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Write strobe for the limit register |
| cfg_wr_data | input | 16 | Write data; bits 7:0 hold the limit in ms |
| cfg_rd_data | output | 16 | Register readback; upper byte is 0 |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| done_map | input | 32 | One bit per queue slot whose transfer has completed |
| active_present | input | 1 | High while the queue holds active transfers |
| irq_clr | input | 1 | Write-one-to-clear strobe for the status bit |
| irq_status | output | 1 | Sticky timeout interrupt status |

## Verification
Two pairs of events can fall in the same clock cycle. A timeout can expire on the same edge as a clear strobe. A counted tick can arrive on the same edge as a restart, caused either by a register write or by a nonzero done map. The bench forces both collisions on purpose. It raises `irq_clr` together with the limit-th tick, and expects the status to stay set. It also drives a tick together with a write, and a tick together with a nonzero done map, and expects no timeout from either. It then checks that the full programmed count is required again after the restart.

// File: rtl/tmo_pkg.sv
package tmo_pkg;
  localparam int unsigned TMO_W_DEF = 8;
  localparam int unsigned MAP_W_DEF = 32;
  localparam int unsigned REG_W_DEF = 16;

  typedef enum logic {
    CNT_ARMED = 1'b0,
    CNT_SPENT = 1'b1
  } cnt_state_t;
endpackage

// File: rtl/tmo_cfg_reg.sv
module tmo_cfg_reg #(
  parameter int unsigned TMO_W     = 8,
  parameter int unsigned REG_W     = 16,
  parameter logic [TMO_W-1:0] RST_VAL = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [TMO_W-1:0] wr_field,
  output logic [TMO_W-1:0] limit,
  output logic [REG_W-1:0] rd_data
);
  localparam int unsigned PAD_W = REG_W - TMO_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      limit <= RST_VAL;
    end else if (wr_en) begin
      limit <= wr_field;
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign rd_data = {{PAD_W{1'b0}}, limit};
    end else begin : g_nopad
      assign rd_data = limit;
    end
  endgenerate
endmodule

// File: rtl/tmo_ms_counter.sv
module tmo_ms_counter
  import tmo_pkg::*;
#(
  parameter int unsigned TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             tick,
  input  logic             active,
  input  logic [TMO_W-1:0] limit,
  output logic             expire
);
  logic [TMO_W-1:0] elapsed;
  logic [TMO_W-1:0] elapsed_inc;
  cnt_state_t       state;
  logic             step;
  logic             hit;

  assign elapsed_inc = elapsed + 1'b1;
  assign step   = tick & active & (state == CNT_ARMED) & (limit != '0) & ~restart;
  assign hit    = (elapsed_inc == limit);
  assign expire = step & hit;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      elapsed <= '0;
      state   <= CNT_ARMED;
    end else if (step) begin
      if (hit) begin
        elapsed <= '0;
        state   <= CNT_SPENT;
      end else begin
        elapsed <= elapsed_inc;
      end
    end
  end
endmodule

// File: rtl/tmo_irq_status.sv
module tmo_irq_status (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic status
);
  always_ff @(posedge clk) begin
    if (rst) begin
      status <= 1'b0;
    end else if (set) begin
      status <= 1'b1;
    end else if (clr) begin
      status <= 1'b0;
    end
  end
endmodule

// File: rtl/xfer_timeout_timer.sv
module xfer_timeout_timer
  import tmo_pkg::*;
#(
  parameter int unsigned TMO_W = TMO_W_DEF,
  parameter int unsigned MAP_W = MAP_W_DEF,
  parameter int unsigned REG_W = REG_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr_en,
  input  logic [REG_W-1:0] cfg_wr_data,
  output logic [REG_W-1:0] cfg_rd_data,
  input  logic             ms_tick,
  input  logic [MAP_W-1:0] done_map,
  input  logic             active_present,
  input  logic             irq_clr,
  output logic             irq_status
);
  logic [TMO_W-1:0] limit;
  logic             any_done;
  logic             restart;
  logic             expire;

  assign any_done = |done_map;
  assign restart  = cfg_wr_en | any_done;

  tmo_cfg_reg #(
    .TMO_W   (TMO_W),
    .REG_W   (REG_W),
    .RST_VAL (TMO_W'(1))
  ) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (cfg_wr_en),
    .wr_field (cfg_wr_data[TMO_W-1:0]),
    .limit    (limit),
    .rd_data  (cfg_rd_data)
  );

  tmo_ms_counter #(
    .TMO_W (TMO_W)
  ) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .tick    (ms_tick),
    .active  (active_present),
    .limit   (limit),
    .expire  (expire)
  );

  tmo_irq_status u_irq (
    .clk    (clk),
    .rst    (rst),
    .set    (expire),
    .clr    (irq_clr),
    .status (irq_status)
  );
endmodule

// File: rtl/xfer_timeout_timer_chk.sv
module xfer_timeout_timer_chk #(
  parameter int unsigned TMO_W = 8,
  parameter int unsigned MAP_W = 32,
  parameter int unsigned REG_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_wr_en,
  input logic [REG_W-1:0] cfg_wr_data,
  input logic [REG_W-1:0] cfg_rd_data,
  input logic             ms_tick,
  input logic [MAP_W-1:0] done_map,
  input logic             active_present,
  input logic             irq_clr,
  input logic             irq_status
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cfg_rd_data == REG_W'(1)) && !irq_status);

  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
    cfg_rd_data[REG_W-1:TMO_W] == '0);

  assert_readback_R2: assert property (@(posedge clk) disable iff (rst)
    cfg_wr_en |=> cfg_rd_data == {{(REG_W-TMO_W){1'b0}}, $past(cfg_wr_data[TMO_W-1:0])});

  assert_reserved_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr_en && cfg_wr_data[REG_W-1:TMO_W] != '0) |=> cfg_rd_data[REG_W-1:TMO_W] == '0);

  assert_fire_cause_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_status) |-> $past(ms_tick && active_present && !cfg_wr_en
                                && cfg_rd_data[TMO_W-1:0] != '0));

  assert_no_fire_on_done_R5: assert property (@(posedge clk) disable iff (rst)
    (done_map != '0) |=> !$rose(irq_status));

  assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (irq_status && !irq_clr) |=> irq_status);

  assert_clear_cause_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_status) |-> $past(irq_clr));

  assert_disabled_R8: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd_data[TMO_W-1:0] == '0) |=> !$rose(irq_status));
endmodule

bind xfer_timeout_timer xfer_timeout_timer_chk #(
  .TMO_W (TMO_W),
  .MAP_W (MAP_W),
  .REG_W (REG_W)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .cfg_wr_en      (cfg_wr_en),
  .cfg_wr_data    (cfg_wr_data),
  .cfg_rd_data    (cfg_rd_data),
  .ms_tick        (ms_tick),
  .done_map       (done_map),
  .active_present (active_present),
  .irq_clr        (irq_clr),
  .irq_status     (irq_status)
);

// File: tb/xfer_timeout_timer_test.sv
`timescale 1ns/1ps
module xfer_timeout_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr_en = 1'b0;
  logic [15:0] cfg_wr_data = '0;
  logic [15:0] cfg_rd_data;
  logic        ms_tick = 1'b0;
  logic [31:0] done_map = '0;
  logic        active_present = 1'b0;
  logic        irq_clr = 1'b0;
  logic        irq_status;

  int checks = 0;
  int errors = 0;
  bit done_run = 1'b0;

  typedef struct {
    logic        irq;
    logic [15:0] rd;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  xfer_timeout_timer uut (
    .clk            (clk),
    .rst            (rst),
    .cfg_wr_en      (cfg_wr_en),
    .cfg_wr_data    (cfg_wr_data),
    .cfg_rd_data    (cfg_rd_data),
    .ms_tick        (ms_tick),
    .done_map       (done_map),
    .active_present (active_present),
    .irq_clr        (irq_clr),
    .irq_status     (irq_status)
  );

  // Monitor: compares design outputs 1 ns after each edge.
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (irq_status !== e.irq || cfg_rd_data !== e.rd) begin
        errors++;
        $display("FAIL %s: irq=%0b rd=%04h expected irq=%0b rd=%04h",
                 e.tag, irq_status, cfg_rd_data, e.irq, e.rd);
      end
    end
  end

  // Driver: applies one cycle of stimulus and queues the post-edge expectation.
  task automatic cyc(input logic wr, input logic [15:0] wd, input logic tick,
                     input logic [31:0] map, input logic act, input logic clr,
                     input logic e_irq, input logic [15:0] e_rd, input string tag);
    @(negedge clk);
    cfg_wr_en = wr; cfg_wr_data = wd; ms_tick = tick;
    done_map = map; active_present = act; irq_clr = clr;
    sb_q.push_back('{e_irq, e_rd, tag});
  endtask

  task automatic flush();
    @(negedge clk);
    cfg_wr_en = 0; ms_tick = 0; done_map = '0; active_present = 0; irq_clr = 0;
    @(posedge clk); #2;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    cyc(0, 0, 0, 0, 0, 0, 0, 16'h0001, "R1 reset");
    // R3 default limit 1 fires on first counted tick
    cyc(0, 0, 1, 0, 1, 0, 1, 16'h0001, "R3 fire at limit 1");
    // R7 sticky
    cyc(0, 0, 0, 0, 1, 0, 1, 16'h0001, "R7 sticky");
    cyc(0, 0, 0, 0, 0, 0, 1, 16'h0001, "R7 sticky idle");
    cyc(0, 0, 0, 0, 1, 1, 0, 16'h0001, "R7 clear");
    // R9 no refire without restart
    cyc(0, 0, 1, 0, 1, 0, 0, 16'h0001, "R9 spent tick1");
    cyc(0, 0, 1, 0, 1, 0, 0, 16'h0001, "R9 spent tick2");
    // R2 readback with reserved bits ignored, R4 restart and new limit
    cyc(1, 16'hAB03, 0, 0, 1, 0, 0, 16'h0003, "R2 upper ignored");
    cyc(0, 0, 1, 0, 1, 0, 0, 16'h0003, "R3 tick1 of 3");
    cyc(0, 0, 0, 0, 1, 0, 0, 16'h0003, "R3 gap");
    cyc(0, 0, 1, 0, 1, 0, 0, 16'h0003, "R3 tick2 of 3");
    cyc(0, 0, 1, 0, 1, 0, 1, 16'h0003, "R3 tick3 fires");
    cyc(0, 0, 0, 0, 1, 1, 0, 16'h0003, "R7 clear 2");
    // R6 inactive ticks not counted
    cyc(1, 16'h0002, 0, 0, 0, 0, 0, 16'h0002, "R2 write 2");
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, 0, 0, 0, 0, 16'h0002, "R6 inactive tick");
    cyc(0, 0, 1, 0, 1, 0, 0, 16'h0002, "R6 active tick1");
    cyc(0, 0, 1, 0, 1, 0, 1, 16'h0002, "R6 active tick2 fires");
    cyc(0, 0, 0, 0, 1, 1, 0, 16'h0002, "R7 clear 3");
    // R5 done map restarts and blocks
    cyc(1, 16'h0002, 0, 0, 1, 0, 0, 16'h0002, "R4 rewrite 2");
    cyc(0, 0, 1, 0, 1, 0, 0, 16'h0002, "R5 tick1");
    cyc(0, 0, 1, 32'h8000_0000, 1, 0, 0, 16'h0002, "R5 tick with done map");
    cyc(0, 0, 1, 0, 1, 0, 0, 16'h0002, "R5 tick1 after restart");
    cyc(0, 0, 0, 32'h0000_0001, 1, 0, 0, 16'h0002, "R5 done map no tick");
    cyc(0, 0, 1, 0, 1, 0, 0, 16'h0002, "R5 tick1 again");
    cyc(0, 0, 1, 0, 1, 0, 1, 16'h0002, "R5 tick2 fires");
    cyc(0, 0, 0, 0, 1, 1, 0, 16'h0002, "R7 clear 4");
    // R8 limit zero disables
    cyc(1, 16'h0000, 0, 0, 1, 0, 0, 16'h0000, "R8 write 0");
    for (int i = 0; i < 6; i++) cyc(0, 0, 1, 0, 1, 0, 0, 16'h0000, "R8 disabled tick");
    // R4 write in the tick cycle is not counted
    cyc(1, 16'h0001, 1, 0, 1, 0, 0, 16'h0001, "R4 tick with write");
    cyc(0, 0, 1, 0, 1, 0, 1, 16'h0001, "R4 next tick fires");
    // R10 set wins over clear
    cyc(1, 16'h0001, 0, 0, 1, 0, 1, 16'h0001, "R10 rearm");
    cyc(0, 0, 1, 0, 1, 1, 1, 16'h0001, "R10 fire with clear");
    cyc(0, 0, 0, 0, 1, 1, 0, 16'h0001, "R10 clear after");
    flush();
    done_run = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done_run) break;
    end
    if (!done_run) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule